// File: doc/BRIEF.md
# Skid-Buffered Stage Stall Controller

This block controls one pipeline stage that sits between an upstream producer, such as a rename stage, and a downstream consumer, such as a commit stage. Each cycle it may receive one instruction group from upstream, along with stall and squash indications from downstream and a full flag from the stage's local issue queue. It tells the stage datapath whether it may work this cycle and which group it should process. It tells upstream when to hold off, and it reports when a squash is in progress. The group payload is opaque to the block.

Groups that arrive while the stage cannot accept them are caught in a small skid buffer, so that nothing in flight is lost. When the stage recovers, the buffered groups are replayed to the datapath one per cycle, oldest first. Upstream stays stalled until the buffer is nearly drained. A squash discards all buffered and arriving groups. The stage then holds until both downstream squash indications have cleared.

Top module: `stall_skid_ctrl`

## Requirements
- R1: After reset, `status` is Idle (code 0), and `up_stall`, `dp_valid`, `squashing` and `skid_err` are low. The first upstream group accepted with no stall, squash or full condition is forwarded, and the status becomes Running (code 1) on the next cycle.
- R2: In Idle or Running, with no downstream stall, no squash flag and no full-plus-valid condition, `dp_run` is high and the upstream group is forwarded combinationally: `dp_valid` equals `up_valid` and `dp_group` equals `up_group` in the same cycle.
- R3: In Idle, Running or Unblocking, a downstream stall takes priority over any squash flag. In that cycle nothing is presented, `dp_run` is low, any arriving group is captured in the skid buffer, and the next status is Blocked (code 2).
- R4: In Running with a valid group and `iq_full` high, the group is captured in the skid buffer, nothing is presented, and the next status is Blocked.
- R5: While the status is Blocked, `up_stall` is high and `dp_run` is low every cycle, and arriving groups are appended to the skid buffer.
- R6: Blocked moves to Unblocking (code 3) only after a cycle in which `dn_stall` and `iq_full` are both low and no squash flag is set. Otherwise it remains Blocked, unless a squash is raised.
- R7: In Unblocking, each cycle without stall, squash or full presents the oldest buffered group on `dp_group` with `dp_valid` high. `up_stall` is high while more than one group is buffered. A newly arriving group is queued behind the buffered groups. The status becomes Running once the buffer is empty.
- R8: In Idle, Running or Unblocking without a downstream stall, `dn_squash` or `dn_rob_squash` moves the stage to Squashing (code 4) on the next cycle. Either flag does the same from Blocked. The skid buffer is emptied, and while squashing, `squashing` is high, nothing is presented and arriving groups are discarded.
- R9: Squashing returns to Running only after a cycle in which both `dn_squash` and `dn_rob_squash` are low.
- R10: A push into a full skid buffer (DEPTH groups held, none leaving) drops that group and leaves the buffered groups intact. It sets `skid_err`, which stays high until reset.
- R11: `status` reports the current state with the codes 0 Idle, 1 Running, 2 Blocked, 3 Unblocking, 4 Squashing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Upstream group present this cycle |
| up_group | input | GROUP_W | Upstream group payload |
| dn_stall | input | 1 | Downstream stall request |
| dn_squash | input | 1 | Downstream squash flag |
| dn_rob_squash | input | 1 | Downstream reorder-buffer squashing flag |
| iq_full | input | 1 | Local issue queue is full |
| up_stall | output | 1 | Stall request to upstream |
| dp_run | output | 1 | Datapath may operate this cycle |
| dp_valid | output | 1 | A group is presented to the datapath |
| dp_group | output | GROUP_W | Group presented to the datapath |
| squashing | output | 1 | Squash in progress |
| skid_err | output | 1 | Sticky skid-buffer overflow flag |
| status | output | 3 | Current state code |

## Verification
On every cycle, the embedded assertions check the following: stall is asserted while Blocked; stall wins over squash in the running path; the Blocked exit depends on the stall and full inputs; Squashing is held while a flag persists; nothing is dispatched during a squash; the buffer count stays within bounds and a dropped push leaves it unchanged; and the error flag is sticky. Only the bench's scenarios can show the rest. That covers the actual replay order of buffered groups, the fact that a squash really discards stale groups so that they never reappear after a later unblock, the drop of the fifth group on overflow, and the exact cycles at which `up_stall` falls while draining.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RUN    = 3'd1,
        ST_BLOCK  = 3'd2,
        ST_UNBLK  = 3'd3,
        ST_SQUASH = 3'd4
    } stage_st_e;

endpackage

// File: rtl/ssc_skid_fifo.sv
module ssc_skid_fifo #(
    parameter int GROUP_W = 16,
    parameter int DEPTH   = 4,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    input  logic               flush,
    input  logic [GROUP_W-1:0] push_data,
    output logic [GROUP_W-1:0] head_data,
    output logic [CNT_W-1:0]   count,
    output logic               ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][GROUP_W-1:0] mem;
        logic [PTR_W-1:0]              rd_ptr;
        logic [PTR_W-1:0]              wr_ptr;
        logic [CNT_W-1:0]              cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic        do_pop, do_push, is_full;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        s_d     = s_q;
        is_full = (s_q.cnt == CNT_W'(DEPTH));
        do_pop  = pop && (s_q.cnt != '0);
        do_push = push && (!is_full || do_pop);
        ovf     = push && is_full && !do_pop && !flush;
        if (flush) begin
            s_d.rd_ptr = '0;
            s_d.wr_ptr = '0;
            s_d.cnt    = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wr_ptr] = push_data;
                s_d.wr_ptr          = ptr_inc(s_q.wr_ptr);
            end
            if (do_pop) begin
                s_d.rd_ptr = ptr_inc(s_q.rd_ptr);
            end
            case ({do_push, do_pop})
                2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
                2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
                default: s_d.cnt = s_q.cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_data = s_q.mem[s_q.rd_ptr];
    assign count     = s_q.cnt;

    // R10: occupancy never exceeds the configured depth
    a_r10_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CNT_W'(DEPTH));

    // R10: a dropped push leaves the held groups untouched
    a_r10_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (count == $past(count)));

endmodule

// File: rtl/ssc_status_fsm.sv
module ssc_status_fsm
    import ssc_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    input  logic             dn_stall,
    input  logic             dn_squash,
    input  logic             dn_rob_squash,
    input  logic             iq_full,
    input  logic [CNT_W-1:0] skid_cnt,
    input  logic             ovf,
    output logic             push,
    output logic             pop,
    output logic             flush,
    output logic             from_skid,
    output logic             up_stall,
    output logic             dp_run,
    output logic             dp_valid,
    output logic             squashing,
    output logic             skid_err,
    output logic [2:0]       status
);

    typedef struct packed {
        stage_st_e st;
        logic      err;
    } fsm_state_t;

    fsm_state_t s_d, s_q;
    logic       sq_any;

    assign sq_any = dn_squash | dn_rob_squash;

    always_comb begin
        s_d       = s_q;
        push      = 1'b0;
        pop       = 1'b0;
        flush     = 1'b0;
        from_skid = 1'b0;
        up_stall  = 1'b0;
        dp_run    = 1'b0;
        dp_valid  = 1'b0;
        s_d.err   = s_q.err | ovf;
        case (s_q.st)
            ST_IDLE, ST_RUN: begin
                if (dn_stall) begin
                    push   = up_valid;
                    s_d.st = ST_BLOCK;
                end else if (sq_any) begin
                    flush  = 1'b1;
                    s_d.st = ST_SQUASH;
                end else if (iq_full && up_valid) begin
                    push   = 1'b1;
                    s_d.st = ST_BLOCK;
                end else begin
                    dp_run   = 1'b1;
                    dp_valid = up_valid;
                    if (up_valid) begin
                        s_d.st = ST_RUN;
                    end
                end
            end
            ST_UNBLK: begin
                up_stall = (skid_cnt > CNT_W'(1));
                if (dn_stall) begin
                    push   = up_valid;
                    s_d.st = ST_BLOCK;
                end else if (sq_any) begin
                    flush  = 1'b1;
                    s_d.st = ST_SQUASH;
                end else if (iq_full) begin
                    push   = up_valid;
                    s_d.st = ST_BLOCK;
                end else if (skid_cnt == '0) begin
                    dp_run   = 1'b1;
                    dp_valid = up_valid;
                    s_d.st   = ST_RUN;
                end else begin
                    dp_run    = 1'b1;
                    dp_valid  = 1'b1;
                    from_skid = 1'b1;
                    pop       = 1'b1;
                    push      = up_valid;
                    if ((skid_cnt == CNT_W'(1)) && !up_valid) begin
                        s_d.st = ST_RUN;
                    end
                end
            end
            ST_BLOCK: begin
                up_stall = 1'b1;
                if (sq_any) begin
                    flush  = 1'b1;
                    s_d.st = ST_SQUASH;
                end else begin
                    push = up_valid;
                    if (!dn_stall && !iq_full) begin
                        s_d.st = ST_UNBLK;
                    end
                end
            end
            ST_SQUASH: begin
                if (!sq_any) begin
                    s_d.st = ST_RUN;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st  <= ST_IDLE;
            s_q.err <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign status    = s_q.st;
    assign squashing = (s_q.st == ST_SQUASH);
    assign skid_err  = s_q.err;

    // R5: upstream is held on every Blocked cycle
    a_r5_stall_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_BLOCK) |-> (up_stall && !dp_run));

    // R3: a stall in the running path always lands in Blocked, squash or not
    a_r3_stall_first: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st inside {ST_IDLE, ST_RUN, ST_UNBLK}) && dn_stall) |=> (status == 3'd2));

    // R6: leaving Blocked for Unblocking needs clear stall and room in the queue
    a_r6_unblock_cond: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_BLOCK) |=> ((status != 3'd3) || $past(!dn_stall && !iq_full && !sq_any)));

    // R9: Squashing persists while either flag is raised
    a_r9_squash_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st == ST_SQUASH) && sq_any) |=> squashing);

    // R8: nothing is dispatched during a squash
    a_r8_no_dispatch: assert property (@(posedge clk) disable iff (!rst_n)
        squashing |-> (!dp_valid && !dp_run && !push));

    // R10: the overflow flag never clears without reset
    a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        skid_err |=> skid_err);

endmodule

// File: rtl/stall_skid_ctrl.sv
module stall_skid_ctrl #(
    parameter int GROUP_W = 16,
    parameter int DEPTH   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_valid,
    input  logic [GROUP_W-1:0] up_group,
    input  logic               dn_stall,
    input  logic               dn_squash,
    input  logic               dn_rob_squash,
    input  logic               iq_full,
    output logic               up_stall,
    output logic               dp_run,
    output logic               dp_valid,
    output logic [GROUP_W-1:0] dp_group,
    output logic               squashing,
    output logic               skid_err,
    output logic [2:0]         status
);

    localparam int CNT_W = $clog2(DEPTH + 1);

    logic               push, pop, flush, from_skid, ovf;
    logic [CNT_W-1:0]   skid_cnt;
    logic [GROUP_W-1:0] head_data;

    ssc_skid_fifo #(
        .GROUP_W (GROUP_W),
        .DEPTH   (DEPTH),
        .CNT_W   (CNT_W)
    ) skid_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (pop),
        .flush     (flush),
        .push_data (up_group),
        .head_data (head_data),
        .count     (skid_cnt),
        .ovf       (ovf)
    );

    ssc_status_fsm #(
        .CNT_W (CNT_W)
    ) fsm_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .up_valid      (up_valid),
        .dn_stall      (dn_stall),
        .dn_squash     (dn_squash),
        .dn_rob_squash (dn_rob_squash),
        .iq_full       (iq_full),
        .skid_cnt      (skid_cnt),
        .ovf           (ovf),
        .push          (push),
        .pop           (pop),
        .flush         (flush),
        .from_skid     (from_skid),
        .up_stall      (up_stall),
        .dp_run        (dp_run),
        .dp_valid      (dp_valid),
        .squashing     (squashing),
        .skid_err      (skid_err),
        .status        (status)
    );

    // replayed groups take precedence over the live upstream group
    assign dp_group = from_skid ? head_data : up_group;

    // R7: Running is reached from Unblocking only with an empty buffer
    a_r7_drained_exit: assert property (@(posedge clk) disable iff (!rst_n)
        ((status == 3'd1) && ($past(status) == 3'd3)) |-> (skid_cnt == '0));

    // R7: a replayed group is never shown while upstream data is shown
    a_r7_replay_valid: assert property (@(posedge clk) disable iff (!rst_n)
        from_skid |-> (dp_valid && (skid_cnt != '0)));

endmodule

// File: tb/stall_skid_ctrl_tb_top.sv
module stall_skid_ctrl_tb_top;

    localparam int GW = 16;

    typedef struct packed {
        logic          uv;
        logic [GW-1:0] grp;
        logic          st;
        logic          sq;
        logic          rb;
        logic          iqf;
        logic [2:0]    e_status;
        logic          e_stall;
        logic          e_run;
        logic          e_dpv;
        logic [GW-1:0] e_grp;
        logic          e_sqg;
        logic          e_err;
    } vec_t;

    localparam int NV = 34;
    // uv grp st sq rb iqf | status stall run dpv grp sqg err
    localparam vec_t VECS [NV] = '{
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b0}, // 0  R1 idle
        {1'b1,16'h0101,1'b0,1'b0,1'b0,1'b0, 3'd0,1'b0,1'b1,1'b1,16'h0101,1'b0,1'b0}, // 1  R1 R2 first group
        {1'b1,16'h0102,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b1,1'b1,16'h0102,1'b0,1'b0}, // 2  R2 R11 running
        {1'b1,16'h0A01,1'b1,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 3  R3 stall capture
        {1'b1,16'h0A02,1'b1,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 4  R5 blocked push
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1, 3'd2,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 5  R6 full keeps blocked
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 6  R6 release
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b1,1'b1,1'b1,16'h0A01,1'b0,1'b0}, // 7  R7 replay oldest
        {1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 8  R3 stall in unblocking
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 9  R6
        {1'b1,16'h0A03,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b1,1'b1,16'h0A02,1'b0,1'b0}, // 10 R7 new queued behind
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b1,1'b1,16'h0A03,1'b0,1'b0}, // 11 R7 order kept
        {1'b1,16'h0B01,1'b0,1'b0,1'b0,1'b1, 3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 12 R4 full with group
        {1'b0,16'h0000,1'b0,1'b1,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 13 R8 squash beats unblock
        {1'b1,16'hDEAD,1'b0,1'b0,1'b1,1'b0, 3'd4,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0}, // 14 R8 R9 rob flag holds
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0}, // 15 R9 both low
        {1'b1,16'h0C01,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b1,1'b1,16'h0C01,1'b0,1'b0}, // 16 R9 back to running
        {1'b1,16'h0C02,1'b1,1'b1,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 17 R3 stall before squash
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 18 R3 blocked, not squashing
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b1,1'b1,16'h0C02,1'b0,1'b0}, // 19 R8 stale groups gone
        {1'b0,16'h0000,1'b0,1'b1,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 20 R8 squash from running
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd4,1'b0,1'b0,1'b0,16'h0000,1'b1,1'b0}, // 21 R9
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b0}, // 22 R9 R2
        {1'b1,16'hE001,1'b1,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 23 R10 fill
        {1'b1,16'hE002,1'b1,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 24 R10
        {1'b1,16'hE003,1'b1,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 25 R10
        {1'b1,16'hE004,1'b1,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 26 R10 now full
        {1'b1,16'hE005,1'b1,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b0}, // 27 R10 overflow push
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd2,1'b1,1'b0,1'b0,16'h0000,1'b0,1'b1}, // 28 R10 flag set
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b1,1'b1,1'b1,16'hE001,1'b0,1'b1}, // 29 R7 R10 intact
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b1,1'b1,1'b1,16'hE002,1'b0,1'b1}, // 30 R7
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b1,1'b1,1'b1,16'hE003,1'b0,1'b1}, // 31 R7
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd3,1'b0,1'b1,1'b1,16'hE004,1'b0,1'b1}, // 32 R7 last, stall drops
        {1'b0,16'h0000,1'b0,1'b0,1'b0,1'b0, 3'd1,1'b0,1'b1,1'b0,16'h0000,1'b0,1'b1}  // 33 R10 sticky, E005 dropped
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          up_valid = 1'b0, dn_stall = 1'b0, dn_squash = 1'b0;
    logic          dn_rob_squash = 1'b0, iq_full = 1'b0;
    logic [GW-1:0] up_group = '0;
    logic          up_stall, dp_run, dp_valid, squashing, skid_err;
    logic [GW-1:0] dp_group;
    logic [2:0]    status;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    stall_skid_ctrl #(.GROUP_W(GW), .DEPTH(4)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .up_valid      (up_valid),
        .up_group      (up_group),
        .dn_stall      (dn_stall),
        .dn_squash     (dn_squash),
        .dn_rob_squash (dn_rob_squash),
        .iq_full       (iq_full),
        .up_stall      (up_stall),
        .dp_run        (dp_run),
        .dp_valid      (dp_valid),
        .dp_group      (dp_group),
        .squashing     (squashing),
        .skid_err      (skid_err),
        .status        (status)
    );

    task automatic chk(input string req, input string what, input int idx,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s step %0d: actual %0h expected %0h", req, what, idx, act, exp);
        end
    endtask

    task automatic check_reset_state(input int idx);
        chk("R1", "status",    idx, 32'(status),    32'd0);
        chk("R1", "up_stall",  idx, 32'(up_stall),  32'd0);
        chk("R1", "dp_valid",  idx, 32'(dp_valid),  32'd0);
        chk("R1", "squashing", idx, 32'(squashing), 32'd0);
        chk("R1", "skid_err",  idx, 32'(skid_err),  32'd0);
    endtask

    initial begin
        #(20 * 5000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state(-1);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            up_valid      = VECS[i].uv;
            up_group      = VECS[i].grp;
            dn_stall      = VECS[i].st;
            dn_squash     = VECS[i].sq;
            dn_rob_squash = VECS[i].rb;
            iq_full       = VECS[i].iqf;
            #5;
            chk("R11", "status",    i, 32'(status),    32'(VECS[i].e_status));
            chk("R5",  "up_stall",  i, 32'(up_stall),  32'(VECS[i].e_stall));
            chk("R2",  "dp_run",    i, 32'(dp_run),    32'(VECS[i].e_run));
            chk("R7",  "dp_valid",  i, 32'(dp_valid),  32'(VECS[i].e_dpv));
            if (VECS[i].e_dpv) begin
                chk("R7", "dp_group", i, 32'(dp_group), 32'(VECS[i].e_grp));
            end
            chk("R8",  "squashing", i, 32'(squashing), 32'(VECS[i].e_sqg));
            chk("R10", "skid_err",  i, 32'(skid_err),  32'(VECS[i].e_err));
        end

        // R1: reset mid-run clears the sticky flag and returns to Idle
        @(negedge clk);
        up_valid = 1'b0; dn_stall = 1'b1; dn_squash = 1'b0;
        dn_rob_squash = 1'b0; iq_full = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        dn_stall = 1'b0;
        #5;
        check_reset_state(100);

        // R4: full queue with no group keeps the stage running
        @(negedge clk);
        rst_n = 1'b1;
        up_valid = 1'b1; up_group = 16'h7701;
        #5;
        chk("R1", "dp_group", 101, 32'(dp_group), 32'h7701);
        @(negedge clk);
        up_valid = 1'b0; iq_full = 1'b1;
        #5;
        chk("R4", "dp_run", 102, 32'(dp_run), 32'd1);
        @(negedge clk);
        #5;
        chk("R4", "status", 103, 32'(status), 32'd1);
        chk("R4", "up_stall", 103, 32'(up_stall), 32'd0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule